// File: doc/BRIEF.md
# Reed-Solomon Page Check-Symbol Engine

This engine watches the byte stream of a 512-byte flash page as it crosses the flash data bus and divides it, symbol by symbol, by a degree-6 generator polynomial over GF(2^10), with field polynomial x^10+x^3+1. Each data byte is bit-inverted and zero-extended to a 10-bit symbol before it enters the divider. An erased page of all 0xFF bytes therefore divides to a zero remainder, which reads out as an all-ones code. When a page is written, the six remainder symbols form the parity that software stores in the spare area.

When a page is read back, software arms the engine in check mode. It then streams the 512 data bytes followed by the 8 parity bytes it stored earlier. The engine repacks those bytes into six symbols and sends them through the same divider. A non-zero final remainder raises a quick error flag. Software can then read the remainder words and do the error location itself. Command and address sequencing of the flash, and any correction, are handled outside this block.

All control and readout use a small word-addressed 16-bit register port. Reads are combinational from the address.

Top module: `rsecc_page_engine`

## Requirements
- R1: After reset the control word (address 0) and the status word (address 1) read 0, every parity word (addresses 8 to 15) reads 0x00FF and every remainder word (addresses 16 to 23) reads 0x0000.
- R2: A write to address 0 acts as follows. Bit 7 clears the divider state and the byte count; it is self-clearing and never reads back. Bit 6 selects generate mode (1) or check mode (0). Bit 5 enables accepting strobes. Reading address 0 returns bits 6 and 5 as last written, with all other bits zero.
- R3: In generate mode the six parity symbols are the remainder of D(x)·x^6 divided by g(x) = (x+α^0)(x+α^1)…(x+α^5) over GF(2^10) with α = x and field polynomial 0x409. D takes the 512 accepted bytes in arrival order, first byte as highest power, each byte as its bitwise complement zero-extended to 10 bits.
- R4: A page of 512 bytes of 0xFF gives eight parity words that all read 0x00FF.
- R5: Parity packing uses a 64-bit vector filled least-significant bit first. The symbol of highest degree (x^5) goes in bits 9:0, the next in bits 19:10, and so on, with the x^0 symbol in bits 59:50; bits 63:60 are zero. Parity word k (address 8+k) holds the complement of vector byte k in bits 7:0 and zero in bits 15:8, so bits 7:4 of word 7 always read 1.
- R6: In check mode the engine accepts 520 bytes. The first 512 are data, treated as in R3. The last 8 are the stored parity words in order. They are unpacked through the R5 layout back into six symbols, with bits 7:4 of the eighth byte ignored, and each symbol is divided in as soon as its last bit has arrived. Status bit 7 reads 1 from the cycle after the 520th accepted byte if and only if the final remainder is non-zero.
- R7: Remainder word k (address 16+k) holds byte k of the uncomplemented R5 vector of the current remainder, with its bit order reversed: vector bit 0 appears at word bit 7. Bits 15:8 are zero.
- R8: Strobes after the page length (512 in generate mode, 520 in check mode) change neither the remainder nor the status until the next clear.
- R9: Strobes while bit 5 is 0 are ignored. Writing 0 to bit 5 freezes the remainder and count, and setting it again resumes the pass where it stopped.
- R10: A strobe in the same cycle as a clear write is not accepted.
- R11: Status bit 7 reads 0 in generate mode and during a check pass before its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | One flash data byte is on the bus this cycle |
| bus_byte | input | 8 | Flash data byte |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
The hardest conditions to reach from the ports are a failing check pass and the partial-symbol unpacking of the stored parity. Both need a full 520-byte sequence whose last eight bytes match, or deliberately miss, a correct remainder. The bench computes the parity of a random page by polynomial long division. It feeds that parity back as the tail of a check pass, once with the unused nibble corrupted, which must pass, and once each with a data byte and a parity bit flipped, which must fail. The status word is compared against the bench model on every strobe cycle, so an early or late error flag is caught at the exact cycle it appears.

// File: rtl/rsecc_pkg.sv
package rsecc_pkg;

    localparam int SYM_W   = 10;
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;
    localparam int BYTE_W  = 8;
    localparam int MAX_PAR = 16;
    localparam int AW      = 5;

    localparam logic [AW-1:0] A_CTRL = 5'd0;
    localparam logic [AW-1:0] A_STAT = 5'd1;
    localparam logic [AW-1:0] A_PAR  = 5'd8;
    localparam logic [AW-1:0] A_REM  = 5'd16;

    localparam int B_CLR  = 7;
    localparam int B_GEN  = 6;
    localparam int B_FEED = 5;
    localparam int B_ERR  = 7;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic {
        MODE_CHECK = 1'b0,
        MODE_GEN   = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  feed;
    } ctrl_t;

    // multiply by alpha (= x) and reduce
    function automatic sym_t gf_xtime(input sym_t a);
        return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_POLY[SYM_W-1:0] : '0);
    endfunction

    // Horner-style product, most significant multiplier bit first
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        acc = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            acc = gf_xtime(acc);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    // coefficient idx of prod_{r<npar} (x + alpha^r); the monic top term is implicit
    function automatic sym_t gen_coef(input int npar, input int idx);
        sym_t g [MAX_PAR+1];
        sym_t root;
        for (int i = 0; i <= MAX_PAR; i++) g[i] = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int r = 0; r < npar; r++) begin
            for (int j = MAX_PAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
            g[0] = gf_mul(g[0], root);
            root = gf_xtime(root);
        end
        return g[idx];
    endfunction

    function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/rsecc_cell.sv
module rsecc_cell
    import rsecc_pkg::*;
#(
    parameter sym_t COEF = sym_t'(1)
) (
    input  sym_t fb,
    input  sym_t carry_in,
    output sym_t sum_out
);
    // constant GF multiply folds to an XOR network
    assign sum_out = carry_in ^ gf_mul(fb, COEF);
endmodule

// File: rtl/rsecc_lfsr.sv
module rsecc_lfsr
    import rsecc_pkg::*;
#(
    parameter int NPAR = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                shift,
    input  sym_t                sym_in,
    output sym_t [NPAR-1:0]     rem
);
    sym_t            fb;
    sym_t [NPAR-1:0] rem_nx;

    assign fb = sym_in ^ rem[NPAR-1];

    for (genvar j = 0; j < NPAR; j++) begin : g_stage
        localparam sym_t CJ = gen_coef(NPAR, j);
        if (j == 0) begin : g_first
            rsecc_cell #(.COEF(CJ)) u_cell (
                .fb       (fb),
                .carry_in ('0),
                .sum_out  (rem_nx[j])
            );
        end else begin : g_next
            rsecc_cell #(.COEF(CJ)) u_cell (
                .fb       (fb),
                .carry_in (rem[j-1]),
                .sum_out  (rem_nx[j])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rem <= '0;
        end else if (shift) begin
            rem <= rem_nx;
        end
    end

    // R2 / R10: a clear leaves a zero remainder
    a_r2_clear_rem: assert property (@(posedge clk) disable iff (rst)
        clr |=> (rem == '0));

    // R9: no symbol, no change
    a_r9_rem_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !shift) |=> $stable(rem));

endmodule

// File: rtl/rsecc_seq.sv
module rsecc_seq
    import rsecc_pkg::*;
#(
    parameter int PAGE = 512,
    parameter int NPAR = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              feed,
    input  mode_e             mode,
    input  logic              stb,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              sym_vld,
    output sym_t              sym,
    output logic              done
);
    localparam int PBITS   = NPAR * SYM_W;
    localparam int PB      = (PBITS + BYTE_W - 1) / BYTE_W;
    localparam int TOT_MAX = PAGE + PB;
    localparam int CW      = $clog2(TOT_MAX + 1);
    localparam int KW      = (PB > 1) ? $clog2(PB) : 1;

    logic [CW-1:0]        cnt;
    logic [CW-1:0]        total;
    logic [PB*BYTE_W-1:0] pvec;
    logic [PB*BYTE_W-1:0] pvec_nx;
    logic [KW-1:0]        pidx;
    logic                 accept;
    logic                 in_par;
    logic                 par_sym_done;
    logic [BYTE_W-1:0]    inv_b;
    sym_t                 par_sym;
    int                   b_before;
    int                   b_after;
    int                   sel;

    assign total  = (mode == MODE_GEN) ? CW'(PAGE) : CW'(TOT_MAX);
    assign accept = stb && feed && !clr && (cnt < total);
    assign in_par = (cnt >= CW'(PAGE));
    assign pidx   = KW'(cnt - CW'(PAGE));
    assign inv_b  = ~byte_in;
    assign done   = (cnt == total);

    // stored parity arrives as packed bytes; a symbol is released once its top bit is in
    always_comb begin
        pvec_nx = pvec;
        pvec_nx[pidx*BYTE_W +: BYTE_W] = byte_in;
        b_before = (int'(pidx) * BYTE_W) / SYM_W;
        b_after  = ((int'(pidx) + 1) * BYTE_W) / SYM_W;
        if (b_after > NPAR) b_after = NPAR;
        par_sym_done = (b_after > b_before);
        sel = par_sym_done ? b_before : 0;
        par_sym = ~pvec_nx[sel*SYM_W +: SYM_W];
    end

    assign sym     = in_par ? par_sym : {{(SYM_W-BYTE_W){1'b0}}, inv_b};
    assign sym_vld = accept && (!in_par || par_sym_done);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            pvec <= '0;
        end else if (accept) begin
            cnt <= cnt + 1'b1;
            if (in_par) pvec <= pvec_nx;
        end
    end

    // R10: clear wins over a coincident strobe
    a_r10_clear_cnt: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    // R9: strobes are dropped while feeding is off
    a_r9_no_feed_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !feed) |=> $stable(cnt));

    // R8: once the page length is reached the count stops
    a_r8_cap_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && (cnt == total)) |=> $stable(cnt));

endmodule

// File: rtl/rsecc_regs.sv
module rsecc_regs
    import rsecc_pkg::*;
#(
    parameter int NPAR = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [15:0]     wdata,
    input  sym_t [NPAR-1:0] rem,
    input  logic            done,
    output ctrl_t           ctrl,
    output logic            clr,
    output logic [15:0]     rdata
);
    localparam int PBITS = NPAR * SYM_W;
    localparam int PB    = (PBITS + BYTE_W - 1) / BYTE_W;
    localparam int KW    = (PB > 1) ? $clog2(PB) : 1;

    logic                 ctrl_wr;
    logic [PB*BYTE_W-1:0] pk;
    logic [PB*BYTE_W-1:0] pk_par;
    logic [KW-1:0]        par_idx;
    logic [KW-1:0]        rem_idx;
    logic                 err;
    logic                 unused_wbits;

    assign unused_wbits = ^{wdata[15:8], wdata[4:0]};

    assign ctrl_wr = wr && (addr == A_CTRL);
    assign clr     = ctrl_wr && wdata[B_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{mode: MODE_CHECK, feed: 1'b0};
        end else if (ctrl_wr) begin
            ctrl.mode <= mode_e'(wdata[B_GEN]);
            ctrl.feed <= wdata[B_FEED];
        end
    end

    // highest-degree symbol first, lsb first; spare top bits stay zero
    always_comb begin
        pk = '0;
        for (int i = 0; i < NPAR; i++) pk[i*SYM_W +: SYM_W] = rem[NPAR-1-i];
    end

    assign pk_par  = ~pk;
    assign par_idx = KW'(addr - A_PAR);
    assign rem_idx = KW'(addr - A_REM);
    assign err     = (ctrl.mode == MODE_CHECK) && done && (|pk);

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[B_GEN]  = ctrl.mode;
            rdata[B_FEED] = ctrl.feed;
        end else if (addr == A_STAT) begin
            rdata[B_ERR] = err;
        end else if (addr >= A_PAR && addr < A_PAR + AW'(PB)) begin
            rdata[BYTE_W-1:0] = pk_par[par_idx*BYTE_W +: BYTE_W];
        end else if (addr >= A_REM && addr < A_REM + AW'(PB)) begin
            rdata[BYTE_W-1:0] = rev_byte(pk[rem_idx*BYTE_W +: BYTE_W]);
        end
    end

    // R2: mode and feed bits follow the last control write
    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl.feed == $past(wdata[B_FEED])) &&
                    (ctrl.mode == mode_e'($past(wdata[B_GEN]))));

endmodule

// File: rtl/rsecc_page_engine.sv
module rsecc_page_engine
    import rsecc_pkg::*;
#(
    parameter int PAGE = 512,
    parameter int NPAR = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_stb,
    input  logic [7:0]  bus_byte,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);
    ctrl_t           ctrl;
    logic            clr;
    logic            sym_vld;
    sym_t            sym;
    logic            done;
    sym_t [NPAR-1:0] rem;

    rsecc_regs #(.NPAR(NPAR)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rem   (rem),
        .done  (done),
        .ctrl  (ctrl),
        .clr   (clr),
        .rdata (reg_rdata)
    );

    rsecc_seq #(.PAGE(PAGE), .NPAR(NPAR)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .feed    (ctrl.feed),
        .mode    (ctrl.mode),
        .stb     (bus_stb),
        .byte_in (bus_byte),
        .sym_vld (sym_vld),
        .sym     (sym),
        .done    (done)
    );

    rsecc_lfsr #(.NPAR(NPAR)) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .shift  (sym_vld),
        .sym_in (sym),
        .rem    (rem)
    );

endmodule

// File: tb/tb_rsecc_page_engine.sv
module tb_rsecc_page_engine;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_stb = 1'b0;
    logic [7:0]  bus_byte = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    rsecc_page_engine dut (
        .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_byte(bus_byte),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int gl [0:6];
    int mb [0:529];
    int rsd [0:5];
    int m_cnt = 0;
    int m_total = 520;
    bit m_feed = 0;
    bit m_gen = 0;
    bit m_nz = 0;
    logic [7:0] pg [0:519];
    logic [31:0] seed = 32'h1234_5678;

    function automatic int mulr(input int a, input int b);
        int r = 0;
        for (int t = 0; t < 10; t++) begin
            if ((b >> t) & 1) r = r ^ a;
            a = a << 1;
            if (a & 'h400) a = a ^ 'h409;
        end
        return r;
    endfunction

    task automatic build_gen();
        int root = 1;
        for (int i = 0; i <= 6; i++) gl[i] = 0;
        gl[0] = 1;
        for (int r = 0; r < 6; r++) begin
            for (int j = 6; j >= 1; j--) gl[j] = gl[j-1] ^ mulr(gl[j], root);
            gl[0] = mulr(gl[0], root);
            root = mulr(root, 2);
        end
    endtask

    // long division of mb[0..n-1] * x^6 by the generator
    task automatic compute_rem(input int n);
        int w [0:529];
        for (int i = 0; i < n; i++) w[i] = mb[i];
        for (int i = 0; i < 6; i++) w[n+i] = 0;
        for (int i = 0; i < n; i++) begin
            int c = w[i];
            if (c != 0) for (int j = 1; j <= 6; j++) w[i+j] = w[i+j] ^ mulr(c, gl[6-j]);
        end
        for (int d = 0; d < 6; d++) rsd[d] = w[n+5-d];
        m_nz = 0;
        for (int d = 0; d < 6; d++) if (rsd[d] != 0) m_nz = 1;
    endtask

    function automatic logic [63:0] pack_rem();
        logic [63:0] pk = '0;
        for (int i = 0; i < 6; i++) pk[i*10 +: 10] = rsd[5-i][9:0];
        return pk;
    endfunction

    function automatic logic [7:0] bitrev(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic model_data();
        for (int i = 0; i < PAGE; i++) mb[i] = int'(8'hFF ^ pg[i]);
    endtask

    task automatic model_check();
        logic [63:0] sv;
        model_data();
        for (int k = 0; k < 8; k++) sv[k*8 +: 8] = pg[PAGE+k];
        sv = ~sv;
        for (int i = 0; i < 6; i++) mb[PAGE+i] = int'(sv[i*10 +: 10]);
        compute_rem(PAGE + 6);
    endtask

    function automatic logic [15:0] exp_stat();
        return (!m_gen && m_cnt == m_total && m_nz) ? 16'h0080 : 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr_ctrl(input logic [15:0] v, input bit with_stb, input logic [7:0] b);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = v;
        bus_stb = with_stb; bus_byte = b;
        @(posedge clk);
        #1 reg_wr = 1'b0; bus_stb = 1'b0;
        if (v[7]) m_cnt = 0;
        m_gen = v[6]; m_feed = v[5];
        m_total = m_gen ? PAGE : PAGE + 8;
    endtask

    // streams pg[from..to]; the status word is compared on every cycle
    task automatic feed_range(input int from, input int to, input string req);
        for (int i = from; i <= to; i++) begin
            @(negedge clk);
            bus_stb = 1'b1; bus_byte = pg[i]; reg_addr = 5'd1;
            #1 chk(req, reg_rdata, exp_stat());
            @(posedge clk);
            if (m_feed && m_cnt < m_total) m_cnt++;
        end
        @(negedge clk);
        bus_stb = 1'b0; reg_addr = 5'd1;
        #1 chk(req, reg_rdata, exp_stat());
    endtask

    task automatic feed_const(input int n, input logic [7:0] b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_stb = 1'b1; bus_byte = b;
            @(posedge clk);
            if (m_feed && m_cnt < m_total) m_cnt++;
        end
        @(negedge clk);
        bus_stb = 1'b0;
    endtask

    task automatic check_par(input string req);
        logic [63:0] pk = pack_rem();
        logic [15:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(5'(8 + k), v);
            chk(req, v, {8'h00, ~pk[k*8 +: 8]});
        end
    endtask

    task automatic check_rem(input string req);
        logic [63:0] pk = pack_rem();
        logic [15:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(5'(16 + k), v);
            chk(req, v, {8'h00, bitrev(pk[k*8 +: 8])});
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 520; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            pg[i] = seed[23:16];
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [63:0] pk;
        logic [7:0]  sp [0:7];
        build_gen();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        for (int d = 0; d < 6; d++) rsd[d] = 0;
        rd(5'd0, v); chk("R1 ctrl", v, 16'h0000);
        rd(5'd1, v); chk("R1 status", v, 16'h0000);
        check_par("R1 parity");
        check_rem("R1 remainder");

        // R4 blank page, R11 status stays low in generate mode
        for (int i = 0; i < 520; i++) pg[i] = 8'hFF;
        wr_ctrl(16'h00E0, 0, 8'h00);
        rd(5'd0, v); chk("R2 ctrl readback", v, 16'h0060);
        feed_range(0, PAGE - 1, "R11 gen status");
        model_data(); compute_rem(PAGE);
        check_par("R4 blank parity");

        // R3/R5/R7 random page, R8 extra strobes after 512
        fill_random();
        wr_ctrl(16'h00E0, 0, 8'h00);
        feed_range(0, 519, "R8 gen status");
        model_data(); compute_rem(PAGE);
        check_par("R3 R5 parity");
        check_rem("R7 remainder gen");
        pk = pack_rem();
        for (int k = 0; k < 8; k++) sp[k] = ~pk[k*8 +: 8];

        // R6 clean check pass with unused nibble corrupted
        for (int k = 0; k < 8; k++) pg[PAGE+k] = sp[k];
        pg[PAGE+7] = sp[7] & 8'h0F;
        wr_ctrl(16'h00A0, 0, 8'h00);
        model_check();
        feed_range(0, 519, "R6 clean status");
        rd(5'd1, v); chk("R6 clean err", v, 16'h0000);
        check_rem("R7 remainder clean");

        // R6 corrupted data byte
        pg[100] = pg[100] ^ 8'h04;
        wr_ctrl(16'h00A0, 0, 8'h00);
        model_check();
        feed_range(0, 519, "R6 data err status");
        rd(5'd1, v); chk("R6 data err", v, 16'h0080);
        check_rem("R7 remainder err");
        feed_range(0, 7, "R8 check status");
        check_rem("R8 remainder unchanged");

        // R6 corrupted stored parity bit
        pg[100] = pg[100] ^ 8'h04;
        pg[PAGE+3] = pg[PAGE+3] ^ 8'h10;
        wr_ctrl(16'h00A0, 0, 8'h00);
        model_check();
        feed_range(0, 519, "R6 parity err status");
        rd(5'd1, v); chk("R6 parity err", v, 16'h0080);

        // R9 pause and resume
        fill_random();
        wr_ctrl(16'h00E0, 0, 8'h00);
        feed_range(0, 199, "R9 status");
        wr_ctrl(16'h0040, 0, 8'h00);
        rd(5'd0, v); chk("R2 R9 paused ctrl", v, 16'h0040);
        feed_const(50, 8'h3C);
        wr_ctrl(16'h0060, 0, 8'h00);
        rd(5'd0, v); chk("R2 R9 resumed ctrl", v, 16'h0060);
        feed_range(200, PAGE - 1, "R9 status");
        model_data(); compute_rem(PAGE);
        check_par("R9 parity");

        // R10 strobe coincident with clear
        fill_random();
        wr_ctrl(16'h00E0, 1, 8'h5A);
        feed_range(0, PAGE - 1, "R10 status");
        model_data(); compute_rem(PAGE);
        check_par("R10 parity");

        // R2 clear alone
        wr_ctrl(16'h0080, 0, 8'h00);
        rd(5'd0, v); chk("R2 clear ctrl", v, 16'h0000);
        for (int d = 0; d < 6; d++) rsd[d] = 0;
        check_par("R2 cleared parity");

        finish_run();
    end
endmodule